// File: doc/BRIEF.md
# Packed Default Attribute Loader

This block is a register-write front end for a vertex pipeline. Software programs a bank of sixteen fallback attribute vectors, each made of four 24-bit floating-point components (x, y, z, w), through a narrow 32-bit configuration write port. Three value writes carry one whole vector. The block gathers them in a staging buffer, splits the 96 bits into four 24-bit fields with w in the leading bits, and stores the result in the entry chosen by a target-index register. After each good store the index steps on by one, so a run of vectors can be loaded after a single index write.

The stored patterns are raw 24-bit values. The block does not interpret them as numbers. Downstream logic reads any entry through a combinational read port addressed by attribute number. A store aimed at an index outside the bank is dropped, and a one-cycle error pulse reports it.

Top module: `dflt_attr_loader`

## Requirements
- R1: After reset, every entry of the vector bank reads as zero, the write counter is zero, the target index is zero, and the error output is low.
- R2: A write to word address 0x232 loads the full 32-bit write data into the target-index register. Writes to 0x233, 0x234 and 0x235 are value writes. A write to any other address changes no state.
- R3: Value writes fill the staging buffer in order of arrival, whichever of the three value addresses each one uses. A write to the index register between value writes leaves the count of pending value writes unchanged. The third value write completes the vector, and the counter returns to zero.
- R4: On completion, with words A, B and C in arrival order, the stored entry is laid out as follows: w in bits [95:72] equals A[31:8]; z in bits [71:48] equals {A[7:0], B[31:16]}; y in bits [47:24] equals {B[15:0], C[31:24]}; x in bits [23:0] equals C[23:0].
- R5: When a vector completes with the target index below 16, it is written to that entry, and the target index then increases by one.
- R6: When a vector completes with the target index at 16 or above, no entry changes, the target index keeps its value, and `err_o` is high for exactly the one cycle after the completing write.
- R7: `rd_vec` shows the entry selected by `rd_idx` combinationally. Writing one entry leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 10 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 4 | Entry selected for reading |
| rd_vec | output | 96 | Selected entry as {w, z, y, x}, each 24 bits |
| err_o | output | 1 | One-cycle pulse after a vector completes with an out-of-range index |

## Verification
The assertions assume a single configuration port: an index write and a value write can never arrive in the same cycle, and a completing write is the only event that moves the index apart from an index write. The bench drives one write per transaction, with the strobe low between writes, and holds `rd_idx` steady except when the monitor sets it. Before each error-pulse check, the stimulus lets earlier scoreboard items drain, so the one-cycle pulse is sampled in the cycle it belongs to.

// File: rtl/dal_pkg.sv
package dal_pkg;
    localparam int WORD_W   = 32;
    localparam int COMP_W   = 24;
    localparam int NUM_COMP = 4;
    localparam int VEC_W    = COMP_W * NUM_COMP;
    localparam int NUM_WORDS = VEC_W / WORD_W;

    typedef logic [COMP_W-1:0] comp_t;

    // w occupies the most significant field, x the least
    typedef struct packed {
        comp_t w;
        comp_t z;
        comp_t y;
        comp_t x;
    } vec4_t;
endpackage

// File: rtl/dal_stage.sv
module dal_stage #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [WORD_W-1:0]           din,
    output logic                        commit,
    output logic [NUM_WORDS*WORD_W-1:0] words
);
    localparam int CNT_W  = $clog2(NUM_WORDS);
    localparam int HOLD_N = NUM_WORDS - 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_WORDS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]               cnt;
        logic [HOLD_N-1:0][WORD_W-1:0]  hold;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        commit = push && (st_q.cnt == LAST);
        if (push) begin
            if (commit) begin
                st_d.cnt = '0;
            end else begin
                for (int i = 0; i < HOLD_N; i++) begin
                    if (st_q.cnt == CNT_W'(i)) st_d.hold[i] = din;
                end
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        // first arrival lands in the most significant word; the last word bypasses the buffer
        for (int i = 0; i < HOLD_N; i++) begin
            words[(NUM_WORDS-1-i)*WORD_W +: WORD_W] = st_q.hold[i];
        end
        words[WORD_W-1:0] = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the counter never passes the last slot
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    // R3: a push that does not complete advances the count by one
    a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q.cnt != LAST) |=> st_q.cnt == $past(st_q.cnt) + CNT_W'(1));

    // R3: without a push the count holds
    a_r3_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(st_q.cnt));
endmodule

// File: rtl/dal_unpack.sv
module dal_unpack
    import dal_pkg::*;
(
    input  logic [NUM_WORDS*WORD_W-1:0] words,
    output vec4_t                       vec
);
    comp_t comps [NUM_COMP];

    // component k is taken from bit k*COMP_W of the concatenated words,
    // which places w across the tail of word A and x in the low bits of word C
    for (genvar k = 0; k < NUM_COMP; k++) begin : g_field
        assign comps[k] = words[k*COMP_W +: COMP_W];
    end

    assign vec.x = comps[0];
    assign vec.y = comps[1];
    assign vec.z = comps[2];
    assign vec.w = comps[3];
endmodule

// File: rtl/dal_store.sv
module dal_store #(
    parameter int NUM_ENTRIES = 16,
    parameter int ENT_W       = 96
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [$clog2(NUM_ENTRIES)-1:0] waddr,
    input  logic [ENT_W-1:0]               wdata,
    input  logic [$clog2(NUM_ENTRIES)-1:0] raddr,
    output logic [ENT_W-1:0]               rdata
);
    localparam int AW = $clog2(NUM_ENTRIES);

    logic [NUM_ENTRIES-1:0][ENT_W-1:0] mem_d, mem_q;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        always_comb begin
            mem_d[e] = mem_q[e];
            if (we && waddr == AW'(e)) mem_d[e] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];

    // R5: a write lands in the addressed entry
    a_r5_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(waddr)] == $past(wdata));

    // R7: without a write the bank is unchanged
    a_r7_store_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> mem_q == $past(mem_q));
endmodule

// File: rtl/dflt_attr_loader.sv
module dflt_attr_loader
    import dal_pkg::*;
#(
    parameter int              NUM_ENTRIES = 16,
    parameter int              ADDR_W      = 10,
    parameter logic [9:0]      BASE_ADDR   = 10'h232
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [WORD_W-1:0]              wr_data,
    input  logic [$clog2(NUM_ENTRIES)-1:0] rd_idx,
    output logic [VEC_W-1:0]               rd_vec,
    output logic                           err_o
);
    localparam int AW = $clog2(NUM_ENTRIES);
    localparam logic [ADDR_W-1:0] BASE     = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] OFF_LAST = ADDR_W'(NUM_WORDS);
    localparam logic [WORD_W-1:0] LIMIT    = WORD_W'(NUM_ENTRIES);

    typedef struct packed {
        logic [WORD_W-1:0] idx;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0]           offs;
    logic                        idx_wr, val_wr;
    logic                        commit, in_range, store_we;
    logic [NUM_WORDS*WORD_W-1:0] words;
    vec4_t                       vec;

    always_comb begin
        offs   = wr_addr - BASE;
        idx_wr = wr_en && (offs == '0);
        val_wr = wr_en && (offs != '0) && (offs <= OFF_LAST);
    end

    dal_stage #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (val_wr),
        .din    (wr_data),
        .commit (commit),
        .words  (words)
    );

    dal_unpack u_unpack (
        .words (words),
        .vec   (vec)
    );

    always_comb begin
        ctl_d    = ctl_q;
        in_range = ctl_q.idx < LIMIT;
        store_we = commit && in_range;
        ctl_d.err = commit && !in_range;
        if (store_we)    ctl_d.idx = ctl_q.idx + WORD_W'(1);
        else if (idx_wr) ctl_d.idx = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    dal_store #(.NUM_ENTRIES(NUM_ENTRIES), .ENT_W(VEC_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .waddr (ctl_q.idx[AW-1:0]),
        .wdata (vec),
        .raddr (rd_idx),
        .rdata (rd_vec)
    );

    assign err_o = ctl_q.err;

    // R5: a good completion moves the index on by one
    a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && ctl_q.idx < LIMIT) |=> ctl_q.idx == $past(ctl_q.idx) + WORD_W'(1));

    // R6: an out-of-range completion raises the flag and keeps the index
    a_r6_err_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && ctl_q.idx >= LIMIT) |=> (err_o && $stable(ctl_q.idx)));

    // R6: the flag lasts a single cycle
    a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R2: with no write strobe the index holds
    a_r2_idx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_q.idx));
endmodule

// File: tb/dflt_attr_loader_tb.sv
module dflt_attr_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [95:0] rd_vec;
    logic        err_o;

    always #5 clk = ~clk;

    dflt_attr_loader u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_vec(rd_vec), .err_o(err_o)
    );

    typedef struct {
        int          idx;
        logic [95:0] vec;
        bit          chk_vec;
        bit          chk_err;
        bit          err_exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_bad = 0;

    // bench model
    logic [95:0] m_mem [16];
    longint      m_idx;
    int          m_cnt;
    logic [31:0] m_buf [3];

    function automatic logic [95:0] pack3(logic [31:0] a, logic [31:0] b, logic [31:0] c);
        logic [23:0] w, z, y, x;
        w = a[31:8];
        z = {a[7:0], b[31:16]};
        y = {b[15:0], c[31:24]};
        x = c[23:0];
        return {w, z, y, x};
    endfunction

    // monitor: pops expectations and compares against the ports
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            rd_idx = it.idx[3:0];
            #1;
            if (it.chk_vec) begin
                n_chk++;
                if (rd_vec !== it.vec) begin
                    n_bad++;
                    $display("FAIL %s entry %0d: got %h exp %h", it.tag, it.idx, rd_vec, it.vec);
                end
            end
            if (it.chk_err) begin
                n_chk++;
                if (err_o !== it.err_exp) begin
                    n_bad++;
                    $display("FAIL %s err_o: got %b exp %b", it.tag, err_o, it.err_exp);
                end
            end
        end
    end

    task automatic push_item(int idx, logic [95:0] v, bit cv, bit ce, bit ee, string tag);
        item_t it;
        it.idx = idx; it.vec = v; it.chk_vec = cv; it.chk_err = ce; it.err_exp = ee; it.tag = tag;
        q.push_back(it);
    endtask

    // driver: one write, model update, expectation push on completion
    task automatic wr(logic [9:0] a, logic [31:0] d, string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
        if (a == 10'h232) begin
            m_idx = longint'(d);
        end else if (a >= 10'h233 && a <= 10'h235) begin
            m_buf[m_cnt] = d;
            m_cnt++;
            if (m_cnt == 3) begin
                m_cnt = 0;
                if (m_idx < 16) begin
                    m_mem[m_idx] = pack3(m_buf[0], m_buf[1], m_buf[2]);
                    push_item(int'(m_idx), m_mem[m_idx], 1'b1, 1'b1, 1'b0, tag);
                    m_idx++;
                end else begin
                    push_item(0, '0, 1'b0, 1'b1, 1'b1, tag);
                end
                wait (q.size() == 0);
            end
        end
    endtask

    task automatic sweep(string tag);
        for (int e = 0; e < 16; e++) push_item(e, m_mem[e], 1'b1, 1'b0, 1'b0, tag);
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        for (int e = 0; e < 16; e++) m_mem[e] = '0;
        m_idx = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset contents and quiet error flag
        push_item(0, '0, 1'b1, 1'b1, 1'b0, "R1");
        sweep("R1");

        // R1 R4: first vector with no index write lands in entry 0, exact field split
        wr(10'h233, 32'hAABBCCDD, "R1");
        wr(10'h234, 32'h11223344, "R4");
        wr(10'h235, 32'h55667788, "R4");
        push_item(0, 96'hAABBCC_DD1122_334455_667788, 1'b1, 1'b0, 1'b0, "R4");
        wait (q.size() == 0);

        // R3 R5: all three writes to the same value address go to entry 1
        wr(10'h233, 32'h01020304, "R3");
        wr(10'h233, 32'h05060708, "R3");
        wr(10'h233, 32'h090A0B0C, "R3");

        // R3: reverse address order, arrival order still rules (entry 2)
        wr(10'h235, 32'hF0E0D0C0, "R3");
        wr(10'h234, 32'hB0A09080, "R3");
        wr(10'h233, 32'h70605040, "R3");

        // R2: writes outside the map change nothing
        wr(10'h236, 32'hDEADBEEF, "R2");
        wr(10'h231, 32'h00000007, "R2");
        wr(10'h032, 32'h00000009, "R2");
        sweep("R2");
        wr(10'h234, 32'h13579BDF, "R2");
        wr(10'h235, 32'h2468ACE0, "R2");
        wr(10'h233, 32'hFFFFFFFF, "R2"); // entry 3

        // R3: index write between value writes keeps the pending count
        wr(10'h233, 32'h12345678, "R3");
        wr(10'h234, 32'h9ABCDEF0, "R3");
        wr(10'h232, 32'd9, "R3");
        wr(10'h235, 32'h0F1E2D3C, "R3"); // entry 9
        wr(10'h233, 32'h00FF00FF, "R5");
        wr(10'h233, 32'hFF00FF00, "R5");
        wr(10'h233, 32'h80000001, "R5"); // entry 10 via auto-increment

        // R5 R6: last entry, then out of range twice
        wr(10'h232, 32'd15, "R5");
        wr(10'h233, 32'h11111111, "R5");
        wr(10'h234, 32'h22222222, "R5");
        wr(10'h235, 32'h33333333, "R5"); // entry 15, index now 16
        wr(10'h233, 32'h44444444, "R6");
        wr(10'h234, 32'h55555555, "R6");
        wr(10'h235, 32'h66666666, "R6");
        push_item(0, '0, 1'b0, 1'b1, 1'b0, "R6");
        wait (q.size() == 0);
        wr(10'h233, 32'h77777777, "R6");
        wr(10'h233, 32'h88888888, "R6");
        wr(10'h233, 32'h99999999, "R6");
        sweep("R6");

        // R6: a large index also counts as out of range
        wr(10'h232, 32'h00010003, "R6");
        wr(10'h235, 32'hABCDEF01, "R6");
        wr(10'h235, 32'h23456789, "R6");
        wr(10'h235, 32'hCAFEF00D, "R6");

        // R5: index back in range after rewrite (entry 0 overwritten)
        wr(10'h232, 32'd0, "R5");
        wr(10'h234, 32'hA5A5A5A5, "R5");
        wr(10'h234, 32'h5A5A5A5A, "R5");
        wr(10'h234, 32'h3C3C3C3C, "R5");

        // R7: every entry reads back its own content
        sweep("R7");

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule